// File: doc/BRIEF.md
# 4B5B Transmit Code-Group Encoder

This block sits between a MAC transmit interface and the serializer of a 100 Mb/s twisted-pair transmit path. On every clock it takes one 4-bit transmit nibble, qualified by a transmit-enable and a transmit-error input, and produces one 5-bit code-group. A small frame sequencer frames each packet with delimiters. When enable rises, it sends a start-of-stream pair in place of the first preamble byte. It then maps every later nibble through the fixed 4B5B data table. When enable falls, it sends an end-of-stream pair and then idles until the next frame.

A bypass input hands a raw 5-bit symbol straight to the output and returns the sequencer to its idle state. Repeater-style paths use this when they already carry 5-bit symbols. The output is registered, so each code-group appears one clock after the inputs it was computed from.

Top module: `nibble_cg_encoder`

## Requirements
- R1: While `rstN` is low, and after its release while `txEn` and `bypassEn` stay low, `cgOut` is the idle code 11111.
- R2: With no frame in progress and `txEn` low, `cgOut` is 11111 on every clock.
- R3: On the first clock edge that samples `txEn` high from the idle state, `cgOut` becomes J (11000). On the next edge it becomes K (10001). The nibbles sampled on those two edges are discarded as the first preamble byte.
- R4: Every later nibble sampled with `txEn` high and `txErr` low appears one clock later as its data code. The codes for 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: A nibble in the data phase that is sampled with `txErr` high is sent as H (00100) instead of its data code.
- R6: On the first edge that samples `txEn` low after J has been sent, `cgOut` becomes T (01101). On the following edge it becomes R (00111), whatever `txEn` is. After that the output is idle 11111 while `txEn` stays low.
- R7: If `txEn` is high on the edge that ends R, the next code-group is J and a new frame starts at once. A frame that re-asserts during T or R never cuts R short.
- R8: On an edge that samples `bypassEn` high, `cgOut` takes the value of `bypassSym` one clock later. The sequencer returns to idle, so a frame it interrupts ends without T/R.
- R9: Exactly one code-group is emitted per clock, and each depends only on the inputs sampled at the edge that produced it and on the sequencer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Code-group clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEn | input | 1 | Transmit enable from the MAC |
| txErr | input | 1 | Transmit error qualifier for the current nibble |
| txNibble | input | 4 | Transmit data nibble |
| bypassEn | input | 1 | Selects raw 5-bit pass-through |
| bypassSym | input | 5 | Raw symbol used in bypass |
| cgOut | output | 5 | Registered 5-bit code-group |

## Verification
The bench builds the block with the package defaults: 4-bit nibbles and 5-bit code-groups. These are the only widths the fixed code table allows, so every nibble value and every delimiter state can be reached. Directed sequences cover all sixteen data codes, a frame only one nibble long, and enable rising again during T and during R. They also cover errored nibbles and a bypass that cuts into a live frame. A long seeded random run then mixes frames of random length with sparse errors and bypass bursts, so that every sequencer transition is hit many times.

// File: rtl/cg_enc_pkg.sv
package cg_enc_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = NIB_W + 1;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;
  localparam logic [CG_W-1:0] CG_H    = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_J, ST_K, ST_DATA, ST_T, ST_R
  } encState_t;

  // One-hot-or-zero load strobes; all zero means load the idle code
  typedef struct packed {
    logic loadJ;
    logic loadK;
    logic loadData;
    logic loadT;
    logic loadR;
    logic loadBypass;
  } cgStrobe_t;
endpackage

// File: rtl/cg_enc_ctrl.sv
module cg_enc_ctrl
  import cg_enc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEn,
  input  logic      bypassEn,
  output cgStrobe_t strobe
);
  encState_t state, stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    if (bypassEn) begin
      // pass-through aborts any frame in progress (R8)
      stateNxt          = ST_IDLE;
      strobe.loadBypass = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (txEn) begin
          stateNxt     = ST_J;
          strobe.loadJ = 1'b1;
        end
        ST_J: begin
          stateNxt     = ST_K;
          strobe.loadK = 1'b1;
        end
        ST_K, ST_DATA: if (txEn) begin
          stateNxt        = ST_DATA;
          strobe.loadData = 1'b1;
        end else begin
          stateNxt     = ST_T;
          strobe.loadT = 1'b1;
        end
        ST_T: begin
          stateNxt     = ST_R;
          strobe.loadR = 1'b1;
        end
        ST_R: if (txEn) begin
          stateNxt     = ST_J;
          strobe.loadJ = 1'b1;
        end else begin
          stateNxt = ST_IDLE;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/cg_enc_datapath.sv
module cg_enc_datapath
  import cg_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cgStrobe_t        strobe,
  input  logic             txErr,
  input  logic [NIB_W-1:0] txNibble,
  input  logic [CG_W-1:0]  bypassSym,
  output logic [CG_W-1:0]  cgOut
);
  function automatic logic [CG_W-1:0] mapNibble(input logic [NIB_W-1:0] n);
    unique case (n)
      4'h0: mapNibble = 5'b11110;
      4'h1: mapNibble = 5'b01001;
      4'h2: mapNibble = 5'b10100;
      4'h3: mapNibble = 5'b10101;
      4'h4: mapNibble = 5'b01010;
      4'h5: mapNibble = 5'b01011;
      4'h6: mapNibble = 5'b01110;
      4'h7: mapNibble = 5'b01111;
      4'h8: mapNibble = 5'b10010;
      4'h9: mapNibble = 5'b10011;
      4'hA: mapNibble = 5'b10110;
      4'hB: mapNibble = 5'b10111;
      4'hC: mapNibble = 5'b11010;
      4'hD: mapNibble = 5'b11011;
      4'hE: mapNibble = 5'b11100;
      default: mapNibble = 5'b11101;
    endcase
  endfunction

  logic [CG_W-1:0] dataSym, symNxt;

  assign dataSym = txErr ? CG_H : mapNibble(txNibble);

  always_comb begin
    if      (strobe.loadBypass) symNxt = bypassSym;
    else if (strobe.loadJ)      symNxt = CG_J;
    else if (strobe.loadK)      symNxt = CG_K;
    else if (strobe.loadData)   symNxt = dataSym;
    else if (strobe.loadT)      symNxt = CG_T;
    else if (strobe.loadR)      symNxt = CG_R;
    else                        symNxt = CG_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cgOut <= CG_IDLE;
    else       cgOut <= symNxt;
  end
endmodule

// File: rtl/nibble_cg_encoder.sv
module nibble_cg_encoder
  import cg_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             txErr,
  input  logic [NIB_W-1:0] txNibble,
  input  logic             bypassEn,
  input  logic [CG_W-1:0]  bypassSym,
  output logic [CG_W-1:0]  cgOut
);
  cgStrobe_t strobe;

  cg_enc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txEn     (txEn),
    .bypassEn (bypassEn),
    .strobe   (strobe)
  );

  cg_enc_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .txErr     (txErr),
    .txNibble  (txNibble),
    .bypassSym (bypassSym),
    .cgOut     (cgOut)
  );
endmodule

// File: rtl/cg_enc_checker.sv
module cg_enc_checker
  import cg_enc_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            txEn,
  input logic            txErr,
  input logic            bypassEn,
  input logic [CG_W-1:0] bypassSym,
  input logic [CG_W-1:0] cgOut,
  input cgStrobe_t       strobe
);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cgOut == CG_IDLE && !txEn && !bypassEn) |=> cgOut == CG_IDLE);

  assert_j_loaded_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadJ |=> cgOut == CG_J);

  assert_k_after_j_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cgOut == CG_J && !bypassEn && !$past(bypassEn)) |=> cgOut == CG_K);

  assert_err_to_h_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadData && txErr) |=> cgOut == CG_H);

  assert_r_after_t_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cgOut == CG_T && !bypassEn && !$past(bypassEn)) |=> cgOut == CG_R);

  assert_exit_after_r_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cgOut == CG_R && !bypassEn && !$past(bypassEn))
      |=> cgOut == ($past(txEn) ? CG_J : CG_IDLE));

  assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    bypassEn |=> cgOut == $past(bypassSym));

  assert_single_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

bind nibble_cg_encoder cg_enc_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txEn      (txEn),
  .txErr     (txErr),
  .bypassEn  (bypassEn),
  .bypassSym (bypassSym),
  .cgOut     (cgOut),
  .strobe    (strobe)
);

// File: tb/sim_nibble_cg_encoder.sv
`timescale 1ns/1ps
module sim_nibble_cg_encoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEn = 1'b0;
  logic       txErr = 1'b0;
  logic [3:0] txNibble = 4'h0;
  logic       bypassEn = 1'b0;
  logic [4:0] bypassSym = 5'h00;
  logic [4:0] cgOut;

  int checks = 0;
  int errors = 0;
  int mState = 0; // 0 idle, 1 J sent, 2 K sent, 3 data, 4 T sent, 5 R sent
  bit done = 1'b0;

  // data codes, nibble F in the top slice down to nibble 0 in the bottom
  localparam logic [79:0] CODE_TBL = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};

  always #2.5 clk = ~clk;

  nibble_cg_encoder u0 (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txErr(txErr), .txNibble(txNibble),
    .bypassEn(bypassEn), .bypassSym(bypassSym), .cgOut(cgOut));

  function automatic logic [4:0] dataCode(input logic [3:0] n);
    return CODE_TBL[n*5 +: 5];
  endfunction

  task automatic check(input logic [4:0] exp, input string req);
    checks++;
    if (cgOut !== exp) begin
      errors++;
      $display("FAIL %s: cgOut=%b expected=%b at %0t", req, cgOut, exp, $time);
    end
  endtask

  // drive one cycle, predict the code-group, check it after the edge
  task automatic cyc(input bit en, input bit err, input logic [3:0] nib,
                     input bit byp, input logic [4:0] sym);
    logic [4:0] exp;
    string why;
    @(negedge clk);
    txEn = en; txErr = err; txNibble = nib; bypassEn = byp; bypassSym = sym;
    if (byp) begin
      mState = 0; exp = sym; why = "R8";
    end else begin
      case (mState)
        0: if (en) begin mState = 1; exp = 5'b11000; why = "R3"; end
           else begin exp = 5'b11111; why = "R2"; end
        1: begin mState = 2; exp = 5'b10001; why = "R3"; end
        2, 3: if (en) begin
             mState = 3;
             exp = err ? 5'b00100 : dataCode(nib);
             why = err ? "R5" : "R4";
           end else begin mState = 4; exp = 5'b01101; why = "R6"; end
        4: begin mState = 5; exp = 5'b00111; why = en ? "R7" : "R6"; end
        default: if (en) begin mState = 1; exp = 5'b11000; why = "R7"; end
                 else begin mState = 0; exp = 5'b11111; why = "R6"; end
      endcase
    end
    @(posedge clk);
    #1;
    check(exp, why);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    bit en;
    seed = 32'h5eed_41b5;
    void'($urandom(seed));
    // R1: reset value
    repeat (3) @(posedge clk);
    #1 check(5'b11111, "R1");
    @(negedge clk) rstN = 1'b1;
    #1 check(5'b11111, "R1");
    for (int i = 0; i < 3; i++) cyc(0, 0, 4'h0, 0, 5'h00);           // R2
    // R3 R4: preamble byte replaced, then all sixteen data codes
    cyc(1, 0, 4'h5, 0, 0); cyc(1, 0, 4'h5, 0, 0);
    for (int n = 0; n < 16; n++) cyc(1, 0, 4'(n), 0, 0);
    // R6: end delimiter and idle
    for (int i = 0; i < 4; i++) cyc(0, 0, 4'h0, 0, 0);
    // R5: errored nibbles
    cyc(1, 0, 4'h5, 0, 0); cyc(1, 0, 4'h5, 0, 0);
    cyc(1, 1, 4'h3, 0, 0); cyc(1, 0, 4'h3, 0, 0); cyc(1, 1, 4'hF, 0, 0);
    // R7: re-assert during T, then during R only
    cyc(0, 0, 0, 0, 0); cyc(1, 0, 4'h5, 0, 0); cyc(1, 0, 4'h5, 0, 0);
    cyc(1, 0, 4'h5, 0, 0); cyc(1, 0, 4'hA, 0, 0);
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(1, 0, 4'h5, 0, 0);
    cyc(1, 0, 4'h5, 0, 0); cyc(0, 0, 0, 0, 0);
    // one-nibble frame: J, K, T, R
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(1, 0, 4'h5, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0);
    // R8: bypass cuts a live frame, then sequencer restarts from idle
    cyc(1, 0, 4'h5, 0, 0); cyc(1, 0, 4'h5, 0, 0); cyc(1, 0, 4'h7, 0, 0);
    cyc(1, 0, 4'h7, 1, 5'b01010); cyc(1, 0, 4'h7, 1, 5'b00000);
    cyc(1, 0, 4'h7, 0, 0); cyc(1, 0, 4'h7, 0, 0); cyc(0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0);
    // R9: seeded random mix
    en = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 9) == 0) en = ~en;
      cyc(en, $urandom_range(0, 15) == 0, 4'($urandom), $urandom_range(0, 31) == 0,
          5'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule